// File: doc/BRIEF.md
# Dual Reference Clock Output Generator

Two independent channels each pick one of sixteen incoming clocks, divide it by an integer ratio from 1 to 16, and drive the result to an output pin through an enable gate. Board components use these outputs as reference clocks. The configuration for both channels sits in one 32-bit control register. Software writes that register through a plain write port and can read it back at any time.

The sixteen sources are oversampled in the block's own clock domain. Each source passes through a two-stage synchronizer, and both of its edges are detected. Every channel counts half-periods of its chosen source, so the output period is an exact multiple of the source period. The high phase and the low phase each last N+1 source half-periods. A change of configuration is applied only at the end of the current output period. A change of source, or entry into a quiet state, therefore never shortens a pulse. The new source then starts on its own rising edge.

Top module: `refclk_out_pair`

## Requirements
- R1: After reset, `reg_rd_data` reads 0 and both bits of `ref_out` are low.
- R2: When `reg_wr_en` is high and `reg_wr_addr` equals 0x128, the register takes `reg_wr_data` with every bit outside the used fields forced to zero (used mask 0x01FF01FF). The new value appears on `reg_rd_data` from the next cycle on.
- R3: A write strobe to any other address, or `reg_wr_en` low, leaves the register unchanged.
- R4: Each channel c (c = 0 or 1) has three fields at bit base 16·c: divider N at [base+3:base], source select at [base+7:base+4] and enable at base+8. A select value k picks `src_clk[k]`.
- R5: With a valid source and the enable set, the output period is (N+1) periods of the selected source. The output stays high for N+1 source half-periods and low for the other N+1.
- R6: Select codes 3, 4, 11, 12 and 14 are reserved. When a reserved code is selected, the output is low once the current period has ended, and it stays low.
- R7: With the enable bit clear, the output is low once the current period has ended, and it stays low.
- R8: A new divider value takes effect at the next period boundary. Every high pulse around the change has either the old width or the new width.
- R9: On a source change, the current period completes, the output rests low, and the new source starts on its next rising edge. Every high pulse has the full width for the old source or the new source.
- R10: Writing the fields of one channel does not change the waveform of the other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the sources and clocks all state |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 12 | Register write address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Current control register value |
| src_clk | input | 16 | Candidate source clocks, index equals select code |
| ref_out | output | 2 | Reference clock outputs, bit c is channel c |

## Verification
The checks assume that every source level lasts at least two system-clock cycles, so the synchronizers see each edge. They also assume that writes are single-cycle strobes that are synchronous to `clk`. The bench derives every source from the system clock. Each source toggles on the falling edge of `clk`, with a half-period of 2 to 17 cycles. Edges are therefore sampled deterministically, and pulse widths can be compared in whole cycles. Random configurations draw only non-reserved codes for the period checks. Reserved codes are exercised only in directed quiet-output cases.

// File: rtl/rco_pkg.sv
`timescale 1ns/1ps
package rco_pkg;
  localparam int NSRC  = 16;
  localparam int SEL_W = $clog2(NSRC);
  localparam int DIV_W = 4;

  // one channel's field group; packing order matches the register layout
  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
  } chan_cfg_t;

  localparam int CFG_W = $bits(chan_cfg_t);
endpackage

// File: rtl/rco_srcsync.sv
`timescale 1ns/1ps
module rco_srcsync #(
  parameter int N      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  // pipe[0..STAGES-1] synchronize, pipe[STAGES] holds the previous level
  logic [STAGES:0][N-1:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], src};
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign rise[i] =  pipe[STAGES-1][i] & ~pipe[STAGES][i];
    assign fall[i] = ~pipe[STAGES-1][i] &  pipe[STAGES][i];
  end
endmodule

// File: rtl/rco_ctrl_reg.sv
`timescale 1ns/1ps
module rco_ctrl_reg #(
  parameter int                ADDR_W    = 12,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h128,
  parameter logic [DATA_W-1:0] USED_MASK = 32'h01FF01FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] ctrl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (wr_en && wr_addr == CTRL_ADDR)
      ctrl_q <= wr_data & USED_MASK;
  end
endmodule

// File: rtl/rco_chan.sv
`timescale 1ns/1ps
module rco_chan
  import rco_pkg::*;
#(
  parameter logic [NSRC-1:0] RESERVED_MASK = 16'h5818
) (
  input  logic            clk,
  input  logic            rst_n,
  input  chan_cfg_t       cfg,
  input  logic [NSRC-1:0] rise,
  input  logic [NSRC-1:0] fall,
  output logic            out_q
);
  typedef enum logic {ST_STOP, ST_RUN} st_t;

  st_t              st;
  logic [SEL_W-1:0] cur_sel;
  logic [DIV_W-1:0] cur_div;
  logic [DIV_W:0]   hcnt;     // half-period index inside one output period
  logic             cfg_ok;
  logic             run_edge;
  logic             period_end;

  assign cfg_ok     = cfg.en && !RESERVED_MASK[cfg.sel];
  assign run_edge   = rise[cur_sel] | fall[cur_sel];
  assign period_end = (hcnt == {cur_div, 1'b1});   // 2*(N+1)-1

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_STOP;
      cur_sel <= '0;
      cur_div <= '0;
      hcnt    <= '0;
      out_q   <= 1'b0;
    end else begin
      case (st)
        ST_STOP: begin
          cur_sel <= cfg.sel;
          cur_div <= cfg.div;
          hcnt    <= '0;
          if (cfg_ok && rise[cfg.sel]) begin
            st    <= ST_RUN;
            out_q <= 1'b1;
          end else begin
            out_q <= 1'b0;
          end
        end
        ST_RUN: begin
          if (run_edge) begin
            if (period_end) begin
              hcnt <= '0;
              if (cfg_ok && cfg.sel == cur_sel) begin
                out_q   <= 1'b1;
                cur_div <= cfg.div;
              end else begin
                st    <= ST_STOP;
                out_q <= 1'b0;
              end
            end else begin
              hcnt  <= hcnt + 1'b1;
              out_q <= (hcnt < {1'b0, cur_div});
            end
          end
        end
        default: st <= ST_STOP;
      endcase
    end
  end
endmodule

// File: rtl/refclk_out_pair.sv
`timescale 1ns/1ps
module refclk_out_pair
  import rco_pkg::*;
#(
  parameter int                ADDR_W        = 12,
  parameter int                DATA_W        = 32,
  parameter logic [ADDR_W-1:0] CTRL_ADDR     = 12'h128,
  parameter int                NCH           = 2,
  parameter int                CH_STRIDE     = 16,
  parameter int                SYNC_STAGES   = 2,
  parameter logic [NSRC-1:0]   RESERVED_MASK = 16'h5818
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_wr_addr,
  input  logic [DATA_W-1:0] reg_wr_data,
  output logic [DATA_W-1:0] reg_rd_data,
  input  logic [NSRC-1:0]   src_clk,
  output logic [NCH-1:0]    ref_out
);
  function automatic logic [DATA_W-1:0] calc_used();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int c = 0; c < NCH; c++)
      for (int b = 0; b < CFG_W; b++)
        m[c*CH_STRIDE + b] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] USED_MASK = calc_used();

  logic [DATA_W-1:0] ctrl_q;
  logic [NSRC-1:0]   src_rise, src_fall;

  rco_ctrl_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .USED_MASK(USED_MASK)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_addr(reg_wr_addr),
    .wr_data(reg_wr_data), .ctrl_q(ctrl_q)
  );

  rco_srcsync #(.N(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .src(src_clk), .rise(src_rise), .fall(src_fall)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chan_cfg_t cfg;
    assign cfg = ctrl_q[c*CH_STRIDE +: CFG_W];
    rco_chan #(.RESERVED_MASK(RESERVED_MASK)) u_chan (
      .clk(clk), .rst_n(rst_n), .cfg(cfg), .rise(src_rise), .fall(src_fall),
      .out_q(ref_out[c])
    );
  end

  assign reg_rd_data = ctrl_q;
endmodule

// File: rtl/refclk_out_pair_chk.sv
`timescale 1ns/1ps
module refclk_out_pair_chk
  import rco_pkg::*;
#(
  parameter int                ADDR_W        = 12,
  parameter int                DATA_W        = 32,
  parameter logic [ADDR_W-1:0] CTRL_ADDR     = 12'h128,
  parameter int                NCH           = 2,
  parameter int                CH_STRIDE     = 16,
  parameter logic [DATA_W-1:0] USED_MASK     = 32'h01FF01FF,
  parameter logic [NSRC-1:0]   RESERVED_MASK = 16'h5818
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_wr_addr,
  input logic [DATA_W-1:0] reg_wr_data,
  input logic [DATA_W-1:0] reg_rd_data,
  input logic [NCH-1:0]    ref_out
);
  p_write_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_addr == CTRL_ADDR) |=> reg_rd_data == ($past(reg_wr_data) & USED_MASK));

  p_no_write_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_wr_addr == CTRL_ADDR) |=> $stable(reg_rd_data));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    localparam int SEL_LO = c*CH_STRIDE + DIV_W;
    localparam int EN_BIT = SEL_LO + SEL_W;

    p_reserved_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (RESERVED_MASK[reg_rd_data[SEL_LO +: SEL_W]] && !ref_out[c]) |=> !ref_out[c]);

    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_rd_data[EN_BIT] && !ref_out[c]) |=> !ref_out[c]);
  end
endmodule

bind refclk_out_pair refclk_out_pair_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .NCH(NCH),
  .CH_STRIDE(CH_STRIDE), .USED_MASK(USED_MASK), .RESERVED_MASK(RESERVED_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
  .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .ref_out(ref_out)
);

// File: tb/refclk_out_pair_test.sv
`timescale 1ns/1ps
module refclk_out_pair_test;
  localparam logic [11:0] CTRL = 12'h128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [15:0] src = '0;
  logic [1:0]  ref_out;
  int          scnt [16] = '{default: 0};
  int          nchk = 0;
  int          nerr = 0;

  always #2.5 clk = ~clk;

  refclk_out_pair uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_wr_addr(wr_addr),
    .reg_wr_data(wr_data), .reg_rd_data(rd_data), .src_clk(src), .ref_out(ref_out)
  );

  function automatic int half(int k);
    return k + 2;
  endfunction

  function automatic bit resv(int s);
    return s == 3 || s == 4 || s == 11 || s == 12 || s == 14;
  endfunction

  function automatic logic [31:0] fld(int ch, bit en, int sel, int div);
    logic [31:0] v;
    v = {23'd0, en, sel[3:0], div[3:0]};
    return v << (16 * ch);
  endfunction

  always @(negedge clk)
    for (int k = 0; k < 16; k++)
      if (scnt[k] == half(k) - 1) begin
        scnt[k] <= 0;
        src[k]  <= ~src[k];
      end else scnt[k] <= scnt[k] + 1;

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic measure(input int ch, output int hi, output int per, output bit ok);
    bit prev, fell;
    int guard;
    ok = 0; hi = 0; per = 0; fell = 0; guard = 0;
    @(negedge clk);
    prev = ref_out[ch];
    while (guard < 3000) begin
      @(negedge clk);
      guard++;
      if (ref_out[ch] && !prev) break;
      prev = ref_out[ch];
    end
    if (guard >= 3000) return;
    hi = 1; guard = 0;
    while (guard < 3000) begin
      @(negedge clk);
      guard++; per++;
      if (ref_out[ch]) begin
        if (fell) begin ok = 1; break; end
        hi++;
      end else fell = 1;
    end
  endtask

  task automatic settle(input int ch, output int hi, output int per, output bit ok);
    measure(ch, hi, per, ok);
    measure(ch, hi, per, ok);
  endtask

  task automatic count_high(input int ch, input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (ref_out[ch]) n++;
    end
  endtask

  task automatic watch(input int ch, input int cycles, input int wr_at, input logic [31:0] d,
                       input int a, input int b, output int nbad, output int last_hi);
    int run; bit prev, seen;
    run = 0; prev = ref_out[ch]; seen = 0; nbad = 0; last_hi = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (i == wr_at) begin wr_en = 1'b1; wr_addr = CTRL; wr_data = d; end
      else wr_en = 1'b0;
      if (ref_out[ch]) begin
        if (!prev) begin seen = 1; run = 0; end
        run++;
      end else if (prev && seen) begin
        last_hi = run;
        if (run != a && run != b) nbad++;
      end
      prev = ref_out[ch];
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int hi, per, n, nbad, last, s0, s1, d0, d1;
    bit ok;
    logic [31:0] d;
    void'($urandom(32'd7351));
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 register after reset", rd_data, 0);
    chk("R1 outputs after reset", int'(ref_out), 0);

    wr(CTRL, 32'hFFFF_FFFF);
    chk("R2 masked readback", rd_data, 32'h01FF01FF);
    wr(12'h12C, 32'h0);
    chk("R3 other address ignored", rd_data, 32'h01FF01FF);
    @(negedge clk);
    wr_addr = CTRL; wr_data = 32'h0; wr_en = 1'b0;
    @(negedge clk);
    chk("R3 strobe low ignored", rd_data, 32'h01FF01FF);
    wr(CTRL, 32'h0);
    chk("R2 clear readback", rd_data, 0);

    // R4: every connected select code at divide-by-one
    for (int s = 0; s < 16; s++) begin
      if (resv(s)) continue;
      wr(CTRL, fld(0, 1, s, 0));
      settle(0, hi, per, ok);
      chk($sformatf("R4 period for select %0d", s), per, 2 * half(s));
    end

    // R5 extremes
    wr(CTRL, fld(0, 1, 0, 15) | fld(1, 1, 13, 6));
    settle(0, hi, per, ok);
    chk("R5 ch0 divide by 16 high", hi, 2 * 16);
    chk("R5 ch0 divide by 16 period", per, 64);
    settle(1, hi, per, ok);
    chk("R5 ch1 divide by 7 high", hi, 15 * 7);

    // R5 random configurations on both channels
    for (int it = 0; it < 14; it++) begin
      do s0 = $urandom_range(15, 0); while (resv(s0));
      do s1 = $urandom_range(15, 0); while (resv(s1));
      d0 = $urandom_range(15, 0);
      d1 = $urandom_range(15, 0);
      d = ($urandom() & 32'hFE00FE00) | fld(0, 1, s0, d0) | fld(1, 1, s1, d1);
      wr(CTRL, d);
      chk("R2 random readback", rd_data, d & 32'h01FF01FF);
      settle(0, hi, per, ok);
      chk("R5 random ch0 found", ok, 1);
      chk("R5 random ch0 high", hi, half(s0) * (d0 + 1));
      chk("R5 random ch0 period", per, 2 * half(s0) * (d0 + 1));
      settle(1, hi, per, ok);
      chk("R5 random ch1 high", hi, half(s1) * (d1 + 1));
      chk("R5 random ch1 period", per, 2 * half(s1) * (d1 + 1));
    end

    // R6 reserved codes go quiet
    wr(CTRL, fld(0, 1, 3, 2) | fld(1, 1, 14, 1));
    repeat (700) @(negedge clk);
    count_high(0, 400, n);
    chk("R6 ch0 select 3 quiet", n, 0);
    count_high(1, 400, n);
    chk("R6 ch1 select 14 quiet", n, 0);
    chk("R6 reserved code stored", rd_data, fld(0, 1, 3, 2) | fld(1, 1, 14, 1));

    // R7 enable clear goes quiet
    wr(CTRL, fld(0, 1, 5, 2));
    settle(0, hi, per, ok);
    wr(CTRL, fld(0, 0, 5, 2));
    repeat (200) @(negedge clk);
    count_high(0, 400, n);
    chk("R7 disabled ch0 quiet", n, 0);

    // R8 divider change at period boundary
    wr(CTRL, fld(0, 1, 13, 1));
    settle(0, hi, per, ok);
    watch(0, 1200, 100, fld(0, 1, 13, 3), 30, 60, nbad, last);
    chk("R8 no odd pulse width", nbad, 0);
    chk("R8 new width in effect", last, 60);

    // R9 source switch
    wr(CTRL, fld(0, 1, 0, 4));
    settle(0, hi, per, ok);
    watch(0, 1200, 50, fld(0, 1, 15, 4), 10, 85, nbad, last);
    chk("R9 no runt on switch", nbad, 0);
    chk("R9 new source width", last, 85);

    // R10 channel independence
    wr(CTRL, fld(0, 1, 2, 0) | fld(1, 1, 7, 2));
    settle(1, hi, per, ok);
    chk("R10 ch1 before ch0 change", hi, 27);
    wr(CTRL, fld(0, 0, 9, 5) | fld(1, 1, 7, 2));
    measure(1, hi, per, ok);
    chk("R10 ch1 after ch0 change", hi, 27);
    chk("R10 ch1 period unchanged", per, 54);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule